// File: doc/BRIEF.md
# Receive Frame Status Trailer Generator

This block sits on the receive byte stream of an Ethernet MAC, between the deserializer and the buffer writer. Frame bytes (FCS included) pass straight through from the input stream to the output stream. When the last byte of a frame is accepted, the block appends a four-byte status trailer to the output stream, with no idle cycle between. The trailer carries the frame's byte count, four error flags and two saturating event counters. The same four bytes are then held in a status register that software reads one byte at a time.

Both streams use valid/ready. In pass mode the input sees the output's ready unchanged, so back-pressure reaches the source in the same cycle. While the trailer is being sent, input ready is held low. A trailer byte stays on the output until the downstream accepts it. Error and event inputs are plain strobes: collision, overflow and runt strobes may come in any cycle, while the FCS-bad and dribble inputs are sampled only on the accepted last beat. Each counter has its own overflow pulse output, for an interrupt register elsewhere.

Top module: `rx_status_trailer`

## Requirements
- R1: When no trailer is pending, m_valid equals s_valid, m_data equals s_data, s_ready equals m_ready, and m_last is 0.
- R2: In the cycle after the last input beat is accepted (s_valid, s_ready and s_last all high), the output offers trailer byte 0. Bytes 1, 2 and 3 follow, each on the next accepted output beat, and m_last is high only with byte 3. s_ready stays low until byte 3 is accepted, and a byte is held unchanged while m_ready is low.
- R3: Trailer byte 0 holds count bits 7..0, and trailer byte 1 bits 3..0 hold count bits 11..8. The count is the number of accepted input beats in the frame, including the 4 FCS bytes, and it saturates at 4095.
- R4: Trailer byte 1 bit 7 (overflow) is 1 if rx_ovf_evt was high in any cycle since the previous frame end, up to and including the last-beat cycle. Bit 6 (collision) follows the same rule for rx_coll_evt.
- R5: Trailer byte 1 bit 4 (FCS error) equals rx_fcs_bad on the last beat. Bit 5 (framing) is rx_fcs_bad AND rx_dribble on the last beat, so a dribble-only frame shows no framing error.
- R6: Trailer byte 2 is the number of rx_runt_evt cycles and byte 3 the number of rx_coll_evt cycles since the previous frame end, including the last-beat cycle. Each saturates at 255 and restarts from 0 after the frame end.
- R7: irq_runt_ovf is high in exactly the cycles where rx_runt_evt is high while the runt counter already holds 255. irq_coll_ovf follows the same rule for the collision counter.
- R8: rd_data shows status byte N, where N is a pointer. Each rd_en cycle advances the pointer 0,1,2,3 and wraps to 0. A frame end loads the new trailer into the status register and sets the pointer to 0, and this takes priority over rd_en in the same cycle.
- R9: After reset, the output offers no trailer, the counts, flags and counters are 0, rd_data is 0 and both interrupt pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted |
| s_data | input | 8 | Input frame byte |
| s_last | input | 1 | Last byte of frame (FCS byte 4) |
| rx_fcs_bad | input | 1 | FCS check failed (sampled on last beat) |
| rx_dribble | input | 1 | Frame ended off an octet boundary (sampled on last beat) |
| rx_ovf_evt | input | 1 | Receive overflow strobe |
| rx_coll_evt | input | 1 | Receive collision strobe |
| rx_runt_evt | input | 1 | Runt frame seen strobe |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Output byte accepted downstream |
| m_data | output | 8 | Frame byte or trailer byte |
| m_last | output | 1 | Last trailer byte |
| rd_en | input | 1 | Status register read strobe |
| rd_data | output | 8 | Status byte at the read pointer |
| irq_runt_ovf | output | 1 | Runt counter overflow pulse |
| irq_coll_ovf | output | 1 | Collision counter overflow pulse |

## Verification
A wrong beat counter, flag latch or event counter is hidden until a frame ends. It then shows in the trailer bytes on the output stream in the following four accepted cycles, and in the status register from the same edge. A broken stream state shows at once as a gap, a repeated byte, a misplaced m_last or an s_ready that stays low. A wrong read pointer shows on the next rd_data sample. A bench model that is compared on every clock therefore catches each fault within one frame plus four beats.

// File: rtl/rxt_pkg.sv
package rxt_pkg;
  localparam int BYTE_W   = 8;
  localparam int TRL_LEN  = 4;
  localparam int TRL_IDXW = $clog2(TRL_LEN);

  typedef struct packed {
    logic ovf;
    logic coll;
    logic fram;
    logic fcs;
  } rxt_flags_t;

  typedef logic [TRL_LEN-1:0][BYTE_W-1:0] rxt_trailer_t;
endpackage

// File: rtl/rxt_sat_counter.sv
module rxt_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cap_val,
  output logic         wrap
);
  logic [W-1:0] cnt_q;
  logic         full;

  assign full    = &cnt_q;
  assign cap_val = (full || !inc) ? cnt_q : cnt_q + W'(1);
  assign wrap    = inc & full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cap_val;
  end
endmodule

// File: rtl/rxt_frame_acc.sv
module rxt_frame_acc
  import rxt_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             last,
  input  logic             ovf_evt,
  input  logic             coll_evt,
  input  logic             fcs_bad,
  input  logic             dribble,
  output logic             done,
  output logic [CNT_W-1:0] cap_cnt,
  output rxt_flags_t       cap_flags
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q, coll_q;

  assign done    = beat & last;
  assign cap_cnt = (beat && !(&cnt_q)) ? cnt_q + CNT_W'(1) : cnt_q;

  always_comb begin
    cap_flags.ovf  = ovf_q | ovf_evt;
    cap_flags.coll = coll_q | coll_evt;
    cap_flags.fram = fcs_bad & dribble;
    cap_flags.fcs  = fcs_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      coll_q <= 1'b0;
    end else if (done) begin
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      coll_q <= 1'b0;
    end else begin
      cnt_q  <= cap_cnt;
      ovf_q  <= cap_flags.ovf;
      coll_q <= cap_flags.coll;
    end
  end
endmodule

// File: rtl/rxt_status_regfile.sv
module rxt_status_regfile
  import rxt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  rxt_trailer_t       load_data,
  input  logic               rd_en,
  output rxt_trailer_t       bytes_out,
  output logic [BYTE_W-1:0]  rd_data
);
  rxt_trailer_t        bytes_q;
  logic [TRL_IDXW-1:0] ptr_q;

  assign bytes_out = bytes_q;
  assign rd_data   = bytes_q[ptr_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q <= '0;
      ptr_q   <= '0;
    end else if (load) begin
      bytes_q <= load_data;
      ptr_q   <= '0;
    end else if (rd_en) begin
      ptr_q   <= ptr_q + TRL_IDXW'(1);
    end
  end
endmodule

// File: rtl/rxt_trailer_tx.sv
module rxt_trailer_tx
  import rxt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  rxt_trailer_t      trl,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_data,
  output logic              m_last,
  output logic              busy
);
  localparam logic [TRL_IDXW-1:0] LAST_IDX = TRL_IDXW'(TRL_LEN - 1);

  logic                busy_q;
  logic [TRL_IDXW-1:0] idx_q;

  assign busy    = busy_q;
  assign s_ready = !busy_q && m_ready;
  assign m_valid = busy_q || s_valid;
  assign m_data  = busy_q ? trl[idx_q] : s_data;
  assign m_last  = busy_q && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q && m_ready) begin
      if (idx_q == LAST_IDX) busy_q <= 1'b0;
      idx_q <= idx_q + TRL_IDXW'(1);
    end
  end
endmodule

// File: rtl/rx_status_trailer.sv
module rx_status_trailer
  import rxt_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int EVT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  input  logic              rx_fcs_bad,
  input  logic              rx_dribble,
  input  logic              rx_ovf_evt,
  input  logic              rx_coll_evt,
  input  logic              rx_runt_evt,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_data,
  output logic              m_last,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq_runt_ovf,
  output logic              irq_coll_ovf
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic             beat, done, tx_busy;
  logic [CNT_W-1:0] cap_cnt;
  rxt_flags_t       cap_flags;
  logic [EVT_W-1:0] runt_cap, coll_cap;
  rxt_trailer_t     trl_new, trl_q;

  assign beat = s_valid & s_ready;

  rxt_frame_acc #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .beat(beat), .last(s_last),
    .ovf_evt(rx_ovf_evt), .coll_evt(rx_coll_evt),
    .fcs_bad(rx_fcs_bad), .dribble(rx_dribble),
    .done(done), .cap_cnt(cap_cnt), .cap_flags(cap_flags)
  );

  rxt_sat_counter #(.W(EVT_W)) u_runt (
    .clk(clk), .rst_n(rst_n), .inc(rx_runt_evt), .clr(done),
    .cap_val(runt_cap), .wrap(irq_runt_ovf)
  );

  rxt_sat_counter #(.W(EVT_W)) u_coll (
    .clk(clk), .rst_n(rst_n), .inc(rx_coll_evt), .clr(done),
    .cap_val(coll_cap), .wrap(irq_coll_ovf)
  );

  always_comb begin
    trl_new    = '0;
    trl_new[0] = cap_cnt[BYTE_W-1:0];
    trl_new[1] = {cap_flags, cap_cnt[CNT_W-1 -: HI_W]};
    trl_new[2] = runt_cap;
    trl_new[3] = coll_cap;
  end

  rxt_status_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .load(done), .load_data(trl_new),
    .rd_en(rd_en), .bytes_out(trl_q), .rd_data(rd_data)
  );

  rxt_trailer_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load(done), .trl(trl_q),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_last(m_last), .busy(tx_busy)
  );
endmodule

// File: rtl/rxt_checker.sv
module rxt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       s_valid,
  input logic       s_ready,
  input logic       s_last,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       m_last,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic       rx_runt_evt,
  input logic       rx_coll_evt,
  input logic       irq_runt_ovf,
  input logic       irq_coll_ovf,
  input logic       busy
);
  AST_TRAILER_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_last) |=> (m_valid && !s_ready)); // R2
  AST_TRAILER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !m_ready) |=> (m_valid && $stable(m_data))); // R2
  AST_LAST_IN_TRAILER: assert property (@(posedge clk) disable iff (!rst_n)
    m_last |-> (m_valid && !s_ready)); // R2
  AST_RUNT_WRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_runt_ovf |-> rx_runt_evt); // R7
  AST_COLL_WRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_coll_ovf |-> rx_coll_evt); // R7
  AST_RD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !(s_valid && s_ready && s_last)) |=> $stable(rd_data)); // R8
endmodule

bind rx_status_trailer rxt_checker i_rxt_checker (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .s_last(s_last), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .m_last(m_last), .rd_en(rd_en), .rd_data(rd_data),
  .rx_runt_evt(rx_runt_evt), .rx_coll_evt(rx_coll_evt),
  .irq_runt_ovf(irq_runt_ovf), .irq_coll_ovf(irq_coll_ovf), .busy(tx_busy)
);

// File: tb/test_rx_status_trailer.sv
module test_rx_status_trailer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 0, s_last = 0, m_ready = 0, rd_en = 0;
  logic [7:0] s_data = 0;
  logic       rx_fcs_bad = 0, rx_dribble = 0, rx_ovf_evt = 0;
  logic       rx_coll_evt = 0, rx_runt_evt = 0;
  logic       s_ready, m_valid, m_last, irq_runt_ovf, irq_coll_ovf;
  logic [7:0] m_data, rd_data;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference state
  int  mode = 0;          // 0 pass, 1..4 trailer byte index + 1
  int  cnt = 0, runt_c = 0, coll_c = 0, ptr = 0;
  bit  ovf_f = 0, coll_f = 0, hs = 0;
  byte unsigned stat_b[4] = '{0, 0, 0, 0};

  always #2 clk = ~clk;

  rx_status_trailer i_rx_status_trailer (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .rx_fcs_bad(rx_fcs_bad),
    .rx_dribble(rx_dribble), .rx_ovf_evt(rx_ovf_evt),
    .rx_coll_evt(rx_coll_evt), .rx_runt_evt(rx_runt_evt),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .rd_en(rd_en), .rd_data(rd_data), .irq_runt_ovf(irq_runt_ovf),
    .irq_coll_ovf(irq_coll_ovf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    if (mode == 0) begin
      chk(m_valid === s_valid, "R1 m_valid", m_valid, s_valid);
      chk(s_ready === m_ready, "R1 s_ready", s_ready, m_ready);
      chk(m_last === 1'b0, "R1 m_last", m_last, 0);
      if (s_valid) chk(m_data === s_data, "R1 m_data", m_data, s_data);
    end else begin
      chk(m_valid === 1'b1, "R2 m_valid", m_valid, 1);
      chk(s_ready === 1'b0, "R2 s_ready", s_ready, 0);
      chk(m_last === (mode == 4), "R2 m_last", m_last, mode == 4);
      chk(m_data === stat_b[mode-1], "R3 trailer byte", m_data, stat_b[mode-1]);
    end
    chk(rd_data === stat_b[ptr], "R8 rd_data", rd_data, stat_b[ptr]);
    chk(irq_runt_ovf === (rx_runt_evt && runt_c == 255), "R7 runt", irq_runt_ovf,
        rx_runt_evt && runt_c == 255);
    chk(irq_coll_ovf === (rx_coll_evt && coll_c == 255), "R7 coll", irq_coll_ovf,
        rx_coll_evt && coll_c == 255);
  endtask

  task automatic model_update();
    int ncnt, nr, nc;
    hs = (mode == 0) && s_valid && m_ready;
    ncnt = (hs && cnt < 4095) ? cnt + 1 : cnt;
    nr = (rx_runt_evt && runt_c < 255) ? runt_c + 1 : runt_c;
    nc = (rx_coll_evt && coll_c < 255) ? coll_c + 1 : coll_c;
    if (mode > 0 && m_ready) mode = (mode == 4) ? 0 : mode + 1;
    if (hs && s_last) begin
      stat_b[0] = ncnt[7:0];
      stat_b[1] = {ovf_f | rx_ovf_evt, coll_f | rx_coll_evt,
                   rx_fcs_bad & rx_dribble, rx_fcs_bad, 4'(ncnt >> 8)};
      stat_b[2] = nr[7:0];
      stat_b[3] = nc[7:0];
      ptr = 0; mode = 1; cnt = 0; ovf_f = 0; coll_f = 0; runt_c = 0; coll_c = 0;
    end else begin
      cnt = ncnt; runt_c = nr; coll_c = nc;
      ovf_f |= rx_ovf_evt; coll_f |= rx_coll_evt;
      if (rd_en) ptr = (ptr + 1) % 4;
    end
  endtask

  task automatic step(input bit dchk = 0, input logic [7:0] dexp = 0, input string tag = "");
    #1;
    if (dchk) chk(rd_data === dexp, tag, rd_data, dexp);
    compare_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic rd_expect(input logic [7:0] exp, input string tag);
    rd_en = 1;
    step(1, exp, tag);
    rd_en = 0;
  endtask

  task automatic send_frame(input int n, input bit fcs, input bit drib,
                            input int ovf_at, input int coll_at, input int runt_at,
                            input bit bp, input bit rd_last);
    int i = 0, cyc = 0;
    while (i < n) begin
      s_valid     = bp ? (cyc % 4 != 3) : 1'b1;
      m_ready     = bp ? (cyc % 3 != 1) : 1'b1;
      s_data      = 8'(i * 7 + 3);
      s_last      = (i == n - 1);
      rx_fcs_bad  = fcs;
      rx_dribble  = drib;
      rx_ovf_evt  = (i == ovf_at);
      rx_coll_evt = (i == coll_at) || (i == coll_at + 2);
      rx_runt_evt = (i == runt_at);
      rd_en       = rd_last && (i == n - 1);
      step();
      if (hs) i++;
      cyc++;
    end
    {s_valid, s_last, rx_fcs_bad, rx_dribble, rx_ovf_evt, rx_coll_evt, rx_runt_evt, rd_en} = '0;
    while (mode != 0) begin
      m_ready = bp ? (cyc % 3 != 1) : 1'b1;
      step();
      cyc++;
    end
    m_ready = 1;
  endtask

  initial begin
    @(negedge clk);
    #1;
    // R9: reset state
    chk(m_valid === 1'b0, "R9 m_valid", m_valid, 0);
    chk(m_last === 1'b0, "R9 m_last", m_last, 0);
    chk(rd_data === 8'h00, "R9 rd_data", rd_data, 0);
    chk(irq_runt_ovf === 1'b0 && irq_coll_ovf === 1'b0, "R9 irq", irq_runt_ovf, 0);
    @(negedge clk);
    rst_n = 1;
    m_ready = 1;
    step();

    // Frame A: 10 beats, bad FCS with dribble, two collisions, one runt (R3 R4 R5 R6)
    send_frame(10, 1, 1, -1, 2, 4, 0, 0);
    rd_expect(8'd10, "R3 byte0 count");
    rd_expect(8'h70, "R4 R5 byte1 coll+fram+fcs");
    rd_expect(8'd1,  "R6 runt count");
    rd_expect(8'd2,  "R6 coll count");
    rd_expect(8'd10, "R8 pointer wrap");

    // Frame B: 300 beats under back-pressure, overflow, dribble only (R2 R3 R4 R5)
    send_frame(300, 0, 1, 5, -10, -1, 1, 0);
    rd_expect(8'h2C, "R3 low count 300");
    rd_expect(8'h81, "R3 R5 byte1 ovf + count hi, no framing");

    // Counter saturation (R6 R7)
    rx_runt_evt = 1; rx_coll_evt = 1;
    for (int k = 0; k < 260; k++) step();
    rx_runt_evt = 0; rx_coll_evt = 0;
    send_frame(5, 0, 0, -1, -10, -1, 0, 0);
    rd_expect(8'd5,   "R3 short frame");
    rd_expect(8'h40,  "R4 coll flag sticky");
    rd_expect(8'd255, "R6 runt saturated");
    rd_expect(8'd255, "R6 coll saturated");
    send_frame(64, 0, 0, -1, -10, -1, 0, 0);
    rd_expect(8'd64, "R3 count 64");
    rd_expect(8'h00, "R4 flags cleared");
    rd_expect(8'd0,  "R6 runt cleared");
    rd_expect(8'd0,  "R6 coll cleared");

    // Count saturation (R3)
    send_frame(4100, 0, 0, -1, -10, -1, 0, 0);
    rd_expect(8'hFF, "R3 saturated low");
    rd_expect(8'h0F, "R3 saturated high");

    // Read on capture cycle: load wins, pointer restarts (R8)
    send_frame(3, 1, 0, -1, -10, -1, 0, 1);
    rd_expect(8'd3,  "R8 load beats read");
    rd_expect(8'h10, "R5 fcs only");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule